// File: doc/BRIEF.md
# Clock Multiplier Enable and Configuration Interlock

This block is the control side of a clock multiplier. It holds the input-source select, the multiplication factor, the enable bit and the ready-interrupt enable. A simple write-strobe port carries all of them in one control word. A lock-delay counter stands in for the analog loop. Ready rises a fixed number of cycles after enable is set. Ready falls a fixed number of cycles after enable is cleared.

The block guards the configuration. The source and factor fields change only when the multiplier is fully idle, which means enable and ready are both low. Software must therefore clear enable, wait until ready reads low, write the new fields and then set enable again. Fields written together with the enable bit in the same idle write are taken. When ready goes high and the interrupt enable is set, a sticky interrupt flag is raised. Software clears the flag with a write-one-to-clear bit.

Top module: `pll_ctrl_top`

## Requirements
- R1: The write word has these fields: bit 0 is enable, bit 1 is ready-interrupt enable, bit 2 is interrupt clear, bit 3 is source select and bits 7:4 are the multiplication factor. When enable and ready are both low, a write loads source and factor, and the new values appear on the outputs after that clock edge.
- R2: While enable is high, writes leave source and factor unchanged.
- R3: Take the clock edge that captures a write clearing enable while ready is high. Ready stays high through the following STOP_CYCLES edges and goes low on the edge after those.
- R4: While enable is low but ready is still high, writes leave source and factor unchanged.
- R5: The interrupt flag is set on the same edge on which ready rises, and only if the interrupt enable is high at that edge.
- R6: Take the clock edge that captures a write setting enable from idle. Ready goes high LOCK_CYCLES+1 edges after that edge. If enable is cleared before then, ready does not rise.
- R7: The enable and interrupt-enable bits are taken on every write, whatever the lock state.
- R8: Once set, the interrupt flag stays high until a write with the clear bit at 1.
- R9: Reset (rst_ni low) drives enable, ready, interrupt enable, interrupt flag, source and factor to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 8 | Control word (see R1) |
| pll_en_o | output | 1 | Multiplier enable |
| pll_rdy_o | output | 1 | Multiplier locked / still running down |
| irq_en_o | output | 1 | Ready-interrupt enable |
| irq_o | output | 1 | Sticky ready interrupt flag |
| src_sel_o | output | 1 | Input-source select |
| mul_o | output | 4 | Multiplication factor |

## Verification
A lock state that is wrong shows up first on pll_rdy_o. The counter checks catch an edge that is early or late by a single cycle. A leaking interlock changes src_sel_o or mul_o on the very next edge after a blocked write. A stuck lock state would show up several cycles later, as a reconfiguration that is rejected after the stop window has ended. Interrupt mistakes appear on irq_o on the same edge as the rise of ready. Examples are a flag set with the interrupt disabled, or a flag that does not stick.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned IRQ_EN_BIT = 1;
  localparam int unsigned IRQ_CLR_BIT = 2;
  localparam int unsigned SRC_LSB    = 3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOCKING = 2'd1,
    ST_LOCKED  = 2'd2,
    ST_STOPPING = 2'd3
  } lock_state_e;
endpackage

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs #(
  parameter int unsigned SRC_W  = 1,
  parameter int unsigned MUL_W  = 4,
  parameter int unsigned DATA_W = 3 + SRC_W + MUL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rdy_i,
  output logic              en_o,
  output logic              irq_en_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [MUL_W-1:0]  mul_o
);
  import pll_ctrl_pkg::*;
  localparam int unsigned MUL_LSB = SRC_LSB + SRC_W;

  logic cfg_open;
  assign cfg_open = !en_o && !rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      irq_en_o <= 1'b0;
      src_o    <= '0;
      mul_o    <= '0;
    end else if (wr_en_i) begin
      en_o     <= wr_data_i[EN_BIT];
      irq_en_o <= wr_data_i[IRQ_EN_BIT];
      if (cfg_open) begin
        src_o <= wr_data_i[SRC_LSB +: SRC_W];
        mul_o <= wr_data_i[MUL_LSB +: MUL_W];
      end
    end
  end

  assert_cfg_locked_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> ($stable(src_o) && $stable(mul_o)));
  assert_cfg_locked_rundown_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && rdy_i) |=> ($stable(src_o) && $stable(mul_o)));
  assert_en_follows_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (en_o == $past(wr_data_i[EN_BIT])));
endmodule

// File: rtl/pll_ctrl_lock.sv
module pll_ctrl_lock #(
  parameter int unsigned LOCK_CYCLES = 16,
  parameter int unsigned STOP_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rdy_o,
  output logic rdy_set_o
);
  import pll_ctrl_pkg::*;
  localparam int unsigned MAX_C = (LOCK_CYCLES > STOP_CYCLES) ? LOCK_CYCLES : STOP_CYCLES;
  localparam int unsigned CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_CYCLES - 1);

  lock_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign rdy_set_o = (state_q == ST_LOCKING) && en_i && (cnt_q == LOCK_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (en_i) state_d = ST_LOCKING;
      end
      ST_LOCKING: begin
        if (!en_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == LOCK_LAST) begin
          state_d = ST_LOCKED;
          cnt_d   = '0;
        end
      end
      ST_LOCKED: begin
        cnt_d = '0;
        if (!en_i) state_d = ST_STOPPING;
      end
      ST_STOPPING: begin
        // a re-enable during rundown waits for full stop
        if (cnt_q == STOP_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdy_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdy_o   <= (state_d == ST_LOCKED) || (state_d == ST_STOPPING);
    end
  end

  assert_rdy_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(en_i));
  assert_rdy_holds_on_disable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_i) && rdy_o) |=> rdy_o);
endmodule

// File: rtl/pll_ctrl_irq.sv
module pll_ctrl_irq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rdy_set_i,
  input  logic              irq_en_i,
  output logic              irq_o
);
  import pll_ctrl_pkg::*;

  logic clr;
  assign clr = wr_en_i && wr_data_i[IRQ_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    irq_o <= 1'b0;
    else if (rdy_set_i && irq_en_i) irq_o <= 1'b1;  // new event wins over clear
    else if (clr)                   irq_o <= 1'b0;
  end

  assert_irq_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i));
  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr) |=> irq_o);
endmodule

// File: rtl/pll_ctrl_top.sv
module pll_ctrl_top #(
  parameter int unsigned LOCK_CYCLES = 16,
  parameter int unsigned STOP_CYCLES = 6,
  parameter int unsigned SRC_W       = 1,
  parameter int unsigned MUL_W       = 4,
  parameter int unsigned DATA_W      = 3 + SRC_W + MUL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pll_en_o,
  output logic              pll_rdy_o,
  output logic              irq_en_o,
  output logic              irq_o,
  output logic [SRC_W-1:0]  src_sel_o,
  output logic [MUL_W-1:0]  mul_o
);
  logic rdy_set;

  pll_ctrl_regs #(.SRC_W(SRC_W), .MUL_W(MUL_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .rdy_i    (pll_rdy_o),
    .en_o     (pll_en_o),
    .irq_en_o (irq_en_o),
    .src_o    (src_sel_o),
    .mul_o    (mul_o)
  );

  pll_ctrl_lock #(.LOCK_CYCLES(LOCK_CYCLES), .STOP_CYCLES(STOP_CYCLES)) u_lock (
    .clk_i, .rst_ni,
    .en_i      (pll_en_o),
    .rdy_o     (pll_rdy_o),
    .rdy_set_o (rdy_set)
  );

  pll_ctrl_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .rdy_set_i (rdy_set),
    .irq_en_i  (irq_en_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/pll_ctrl_top_bench.sv
module pll_ctrl_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_C = 8;
  localparam int STOP_C = 5;
  localparam int NVEC = 5;
  // [7:0] write word (enable=0), [11:8] expected factor, [12] expected source
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 4'h3, 8'h38},
    {1'b0, 4'hA, 8'hA0},
    {1'b1, 4'hF, 8'hF8},
    {1'b0, 4'h0, 8'h02},
    {1'b1, 4'h6, 8'h68}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic en, rdy, irq_en, irq, src;
  logic [3:0] mul;
  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctrl_top #(.LOCK_CYCLES(LOCK_C), .STOP_CYCLES(STOP_C)) u_pll_ctrl_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .pll_en_o(en), .pll_rdy_o(rdy), .irq_en_o(irq_en), .irq_o(irq),
    .src_sel_o(src), .mul_o(mul)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(2);
    chk("R9 reset outputs", {26'd0, en, rdy, irq_en, irq, src, |mul}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1: idle writes load the fields
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][7:0]);
      chk("R1 src", src, VEC[i][12]);
      chk("R1 mul", mul, VEC[i][11:8]);
    end

    // R6/R5: enable with fields and irq enable in one idle write
    wr(8'h5B);                         // mul=5 src=1 irq_en en
    chk("R1 cfg with enable", {src, mul}, {1'b1, 4'h5});
    chk("R7 enable taken", {en, irq_en}, 2'b11);
    wait_cyc(LOCK_C);
    chk("R6 not ready early", rdy, 1'b0);
    chk("R5 no irq before ready", irq, 1'b0);
    wait_cyc(1);
    chk("R6 ready on time", rdy, 1'b1);
    chk("R5 irq with ready", irq, 1'b1);

    // R2: enabled, config write ignored
    wr(8'hC3);
    chk("R2 cfg blocked", {src, mul}, {1'b1, 4'h5});
    chk("R8 irq sticky", irq, 1'b1);
    wr(8'h07);                         // W1C
    chk("R8 irq cleared", irq, 1'b0);

    // R3/R4: disable then attempt writes during rundown
    wr(8'h92);                         // en=0, mul=9, src=0 (blocked: en was 1)
    chk("R7 disable taken", en, 1'b0);
    chk("R2 cfg blocked on disable", {src, mul}, {1'b1, 4'h5});
    wr(8'h92);                         // en=0, rdy=1: blocked
    chk("R4 cfg blocked in rundown", {src, mul}, {1'b1, 4'h5});
    wait_cyc(STOP_C - 1);
    chk("R3 ready held", rdy, 1'b1);
    wait_cyc(1);
    chk("R3 ready dropped", rdy, 1'b0);

    wr(8'h92);
    chk("R1 cfg after stop", {src, mul}, {1'b0, 4'h9});

    // R5: ready with irq disabled
    wr(8'h91);
    wait_cyc(LOCK_C + 1);
    chk("R6 relock", rdy, 1'b1);
    chk("R5 no irq when disabled", irq, 1'b0);

    // R6: abort during locking
    wr(8'h90);
    wait_cyc(STOP_C + 1);
    chk("R3 stopped", rdy, 1'b0);
    wr(8'h91);
    wait_cyc(2);
    wr(8'h90);
    wait_cyc(LOCK_C + 2);
    chk("R6 aborted lock", rdy, 1'b0);

    // R9: reset mid-operation
    wr(8'hF7);
    wait_cyc(LOCK_C + 1);
    chk("R6 locked before reset", {rdy, irq}, 2'b11);
    rst_n = 1'b0;
    wait_cyc(1);
    chk("R9 reset clears", {26'd0, en, rdy, irq_en, irq, src, |mul}, 32'd0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule